// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general registers and saved status words for a 32-bit processor that has several operating modes. Instruction logic gives it a 4-bit register number on each of two read ports and one write port, plus the current mode. The mode decides which physical copy of a register each access reaches. Registers 0 to 7 are common to every mode. The fast-interrupt mode has its own copies of registers 8 to 14. The other four exception modes have their own copies of registers 13 and 14 only. The privileged system mode works on the plain user set.

Register number 15 is the program counter. That value lives outside this block and comes in on `pc_i`, so reading number 15 returns that input and writing number 15 does nothing here. A separate port reads and writes the saved status word of the current mode. Each of the five exception modes has one such word. User and system modes have none.

Both read ports are combinational views of the stored state. Writes take effect at the clock edge. A read in the same cycle as a write to the same register therefore returns the old contents.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears every stored general register and every saved status word to zero at the clock edge.
- R2: Registers 0 to 7 are one physical set shared by every mode. A write in any mode is read back from the same number in every other mode.
- R3: Mode `5'b10001` (fast interrupt) reaches private copies of registers 8 to 14. It leaves the copies seen by all other modes untouched.
- R4: Modes `5'b10010`, `5'b10011`, `5'b10111` and `5'b11011` (interrupt, supervisor, abort, undefined) each reach their own copy of registers 13 and 14. For registers 8 to 12 they reach the user copy.
- R5: Mode `5'b11111` (system), mode `5'b10000` (user) and every mode value not listed in R3 or R4 all reach the user set for registers 0 to 14.
- R6: Reading register 15 on either port returns `pc_i` in the same cycle. A write to register 15 changes no stored register.
- R7: Each of the five exception modes has its own saved status word. It is written through `psr_wr_en_i`/`psr_wr_data_i` and read on `psr_rd_data_o`.
- R8: In user mode, in system mode and for unlisted mode values, `psr_rd_data_o` reads zero and a saved status write changes nothing.
- R9: A read of the register being written in the same cycle returns the old value. The new value appears from the next cycle.
- R10: The two read ports are independent. Each returns its own register for its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current processor mode |
| rd_a_idx_i | input | 4 | Register number for read port A |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Register number for read port B |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General register write enable |
| wr_idx_i | input | 4 | Register number to write |
| wr_data_i | input | 32 | Write data |
| pc_i | input | 32 | Program counter value returned for register 15 |
| psr_wr_en_i | input | 1 | Saved status word write enable |
| psr_wr_data_i | input | 32 | Saved status word write data |
| psr_rd_data_o | output | 32 | Saved status word of the current mode |

## Verification
The checker assumes that `mode_i` and the indices change only between clock edges. Its write-visibility properties only look at cycles where the mode is the same at the write and at the following read, because a mode change redirects the read to a different bank. The stimulus changes every input just after the falling edge. Mode values are drawn from all seven legal codes and also from unlisted codes, so the properties see both held-mode and switching-mode cycles. Reset is pulsed mid-run, and the properties exclude the first cycle after a reset so that no write made during reset is counted.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    localparam int DW        = 32;
    localparam int IDX_W     = 4;
    localparam int MODE_W    = 5;
    localparam int PC_IDX    = 15;

    // Physical layout of the general slots
    localparam int USR_LEN     = 15;                 // r0..r14
    localparam int FIQ_FIRST   = 8;                  // first privately held index in fast-interrupt mode
    localparam int FIQ_LEN     = PC_IDX - FIQ_FIRST; // r8..r14
    localparam int SHORT_FIRST = 13;                 // first privately held index in other exception modes
    localparam int SHORT_LEN   = PC_IDX - SHORT_FIRST;
    localparam int NUM_SHORT   = 4;
    localparam int FIQ_BASE    = USR_LEN;
    localparam int SHORT_BASE  = FIQ_BASE + FIQ_LEN;
    localparam int NUM_GPR     = SHORT_BASE + NUM_SHORT * SHORT_LEN;
    localparam int SLOT_W      = $clog2(NUM_GPR);

    localparam int NUM_SPSR    = NUM_SHORT + 1;
    localparam int SPSR_W      = $clog2(NUM_SPSR);

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } mode_e;

    // Order matters: the short banks follow FIQ in this order
    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

    typedef struct packed {
        logic [NUM_GPR-1:0][DW-1:0]  gpr;
        logic [NUM_SPSR-1:0][DW-1:0] spsr;
    } regstate_t;

endpackage

// File: rtl/bankreg_mode_dec.sv
module bankreg_mode_dec
    import bankreg_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output bank_e             bank_o,
    output logic              has_spsr_o,
    output logic [SPSR_W-1:0] spsr_sel_o
);

    always_comb begin
        bank_o = BANK_USR;
        case (mode_e'(mode_i))
            MODE_FIQ: bank_o = BANK_FIQ;
            MODE_IRQ: bank_o = BANK_IRQ;
            MODE_SVC: bank_o = BANK_SVC;
            MODE_ABT: bank_o = BANK_ABT;
            MODE_UND: bank_o = BANK_UND;
            default:  bank_o = BANK_USR;   // user, system and unlisted codes
        endcase
    end

    assign has_spsr_o = (bank_o != BANK_USR);
    assign spsr_sel_o = has_spsr_o ? SPSR_W'(int'(bank_o) - int'(BANK_FIQ)) : '0;

endmodule

// File: rtl/bankreg_map.sv
module bankreg_map
    import bankreg_pkg::*;
(
    input  bank_e             bank_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              is_pc_o
);

    int idx_n;
    int short_k;

    always_comb begin
        idx_n   = int'(idx_i);
        short_k = int'(bank_i) - int'(BANK_IRQ);
        is_pc_o = (idx_n == PC_IDX);
        slot_o  = SLOT_W'(idx_n);
        if (!is_pc_o) begin
            if (bank_i == BANK_FIQ && idx_n >= FIQ_FIRST) begin
                slot_o = SLOT_W'(FIQ_BASE + idx_n - FIQ_FIRST);
            end else if (bank_i != BANK_USR && bank_i != BANK_FIQ && idx_n >= SHORT_FIRST) begin
                slot_o = SLOT_W'(SHORT_BASE + short_k * SHORT_LEN + idx_n - SHORT_FIRST);
            end
        end else begin
            slot_o = '0;
        end
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bankreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [IDX_W-1:0]  rd_a_idx_i,
    output logic [DW-1:0]     rd_a_data_o,
    input  logic [IDX_W-1:0]  rd_b_idx_i,
    output logic [DW-1:0]     rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DW-1:0]     wr_data_i,
    input  logic [DW-1:0]     pc_i,
    input  logic              psr_wr_en_i,
    input  logic [DW-1:0]     psr_wr_data_i,
    output logic [DW-1:0]     psr_rd_data_o
);

    localparam int NUM_PORTS = 3;   // 0: read A, 1: read B, 2: write
    localparam int WR_PORT   = 2;

    bank_e             bank;
    logic              has_spsr;
    logic [SPSR_W-1:0] spsr_sel;

    logic [NUM_PORTS-1:0][IDX_W-1:0]  port_idx;
    logic [NUM_PORTS-1:0][SLOT_W-1:0] port_slot;
    logic [NUM_PORTS-1:0]             port_pc;

    regstate_t st_d, st_q;

    bankreg_mode_dec u_dec (
        .mode_i     (mode_i),
        .bank_o     (bank),
        .has_spsr_o (has_spsr),
        .spsr_sel_o (spsr_sel)
    );

    assign port_idx = {wr_idx_i, rd_b_idx_i, rd_a_idx_i};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        bankreg_map u_map (
            .bank_i  (bank),
            .idx_i   (port_idx[p]),
            .slot_o  (port_slot[p]),
            .is_pc_o (port_pc[p])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i && !port_pc[WR_PORT]) begin
            st_d.gpr[port_slot[WR_PORT]] = wr_data_i;
        end
        if (psr_wr_en_i && has_spsr) begin
            st_d.spsr[spsr_sel] = psr_wr_data_i;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_a_data_o   = port_pc[0] ? pc_i : st_q.gpr[port_slot[0]];
    assign rd_b_data_o   = port_pc[1] ? pc_i : st_q.gpr[port_slot[1]];
    assign psr_rd_data_o = has_spsr ? st_q.spsr[spsr_sel] : '0;

endmodule

// File: rtl/bankreg_checker.sv
module bankreg_checker
    import bankreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [MODE_W-1:0] mode_i,
    input logic [IDX_W-1:0]  rd_a_idx_i,
    input logic [DW-1:0]     rd_a_data_o,
    input logic [IDX_W-1:0]  rd_b_idx_i,
    input logic [DW-1:0]     rd_b_data_o,
    input logic              wr_en_i,
    input logic [IDX_W-1:0]  wr_idx_i,
    input logic [DW-1:0]     wr_data_i,
    input logic [DW-1:0]     pc_i,
    input logic              psr_wr_en_i,
    input logic [DW-1:0]     psr_wr_data_i,
    input logic [DW-1:0]     psr_rd_data_o
);

    logic no_spsr_mode;
    assign no_spsr_mode = !(mode_i inside {MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND});

    // R1: first cycle after reset, port A sees zero for any stored register
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && rd_a_idx_i != 4'd15) |-> (rd_a_data_o == '0));

    // R6: register 15 reads the external program counter
    p_pc_read_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx_i == 4'd15) |-> (rd_b_data_o == pc_i));

    // R8: modes without a saved status word read zero
    p_spsr_none_r8: assert property (@(posedge clk) disable iff (rst)
        no_spsr_mode |-> (psr_rd_data_o == '0));

    // R7: saved status write is seen next cycle in the same mode
    p_spsr_write_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(psr_wr_en_i) && !$past(no_spsr_mode) && $stable(mode_i))
        |-> (psr_rd_data_o == $past(psr_wr_data_i)));

    // R9: a written register shows the new value on the following cycle
    p_write_next_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en_i) && $past(wr_idx_i) != 4'd15 &&
         $stable(mode_i) && rd_a_idx_i == $past(wr_idx_i))
        |-> (rd_a_data_o == $past(wr_data_i)));

    // R10: port B tracks writes independently of port A
    p_port_b_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en_i) && $past(wr_idx_i) != 4'd15 &&
         $stable(mode_i) && rd_b_idx_i == $past(wr_idx_i))
        |-> (rd_b_data_o == $past(wr_data_i)));

endmodule

bind banked_regfile bankreg_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_i        (mode_i),
    .rd_a_idx_i    (rd_a_idx_i),
    .rd_a_data_o   (rd_a_data_o),
    .rd_b_idx_i    (rd_b_idx_i),
    .rd_b_data_o   (rd_b_data_o),
    .wr_en_i       (wr_en_i),
    .wr_idx_i      (wr_idx_i),
    .wr_data_i     (wr_data_i),
    .pc_i          (pc_i),
    .psr_wr_en_i   (psr_wr_en_i),
    .psr_wr_data_i (psr_wr_data_i),
    .psr_rd_data_o (psr_rd_data_o)
);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  mode_i;
    logic [3:0]  rd_a_idx_i, rd_b_idx_i, wr_idx_i;
    logic [31:0] rd_a_data_o, rd_b_data_o, psr_rd_data_o;
    logic        wr_en_i, psr_wr_en_i;
    logic [31:0] wr_data_i, pc_i, psr_wr_data_i;

    int vec_cnt = 0;
    int err_cnt = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    banked_regfile u_banked_regfile (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
        .rd_b_idx_i(rd_b_idx_i), .rd_b_data_o(rd_b_data_o),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .pc_i(pc_i), .psr_wr_en_i(psr_wr_en_i), .psr_wr_data_i(psr_wr_data_i),
        .psr_rd_data_o(psr_rd_data_o)
    );

    // Behavioural reference state
    logic [31:0] m_usr [0:14];
    logic [31:0] m_fiq [8:14];
    logic [31:0] m_shr [0:3][0:1];
    logic [31:0] m_psr [0:4];

    logic [4:0] legal_modes [0:7];
    initial begin
        legal_modes[0] = 5'b10000; legal_modes[1] = 5'b10001;
        legal_modes[2] = 5'b10010; legal_modes[3] = 5'b10011;
        legal_modes[4] = 5'b10111; legal_modes[5] = 5'b11011;
        legal_modes[6] = 5'b11111; legal_modes[7] = 5'b01010;
    end

    function automatic int bank_of(logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [31:0] m_read(logic [4:0] m, logic [3:0] idx);
        int b = bank_of(m);
        if (idx == 4'd15) return pc_i;
        if (b == 1 && idx >= 8) return m_fiq[idx];
        if (b >= 2 && idx >= 13) return m_shr[b-2][idx-13];
        return m_usr[idx];
    endfunction

    function automatic logic [31:0] m_psr_read(logic [4:0] m);
        int b = bank_of(m);
        if (b == 0) return 32'h0;
        return m_psr[b-1];
    endfunction

    function automatic string tag_of(logic [4:0] m, logic [3:0] idx);
        int b = bank_of(m);
        if (idx == 4'd15) return "R6";
        if (idx < 8) return "R2";
        if (b == 1) return "R3";
        if (b >= 2) return "R4";
        return "R5";
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 15; i++) m_usr[i] = '0;
        for (int i = 8; i < 15; i++) m_fiq[i] = '0;
        for (int k = 0; k < 4; k++) for (int j = 0; j < 2; j++) m_shr[k][j] = '0;
        for (int k = 0; k < 5; k++) m_psr[k] = '0;
    endtask

    task automatic model_update();
        int b = bank_of(mode_i);
        if (rst) begin
            model_clear();
            return;
        end
        if (wr_en_i && wr_idx_i != 4'd15) begin
            if (b == 1 && wr_idx_i >= 8) m_fiq[wr_idx_i] = wr_data_i;
            else if (b >= 2 && wr_idx_i >= 13) m_shr[b-2][wr_idx_i-13] = wr_data_i;
            else m_usr[wr_idx_i] = wr_data_i;
        end
        if (psr_wr_en_i && b != 0) m_psr[b-1] = psr_wr_data_i;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            err_cnt++;
            $display("FAIL %s mode=%b: actual %h expected %h", tag, mode_i, act, exp);
        end
    endtask

    // Inputs already set after a falling edge; compare, then advance one edge
    task automatic cycle(string extra = "");
        #2;
        check({tag_of(mode_i, rd_a_idx_i), " portA", extra}, rd_a_data_o, m_read(mode_i, rd_a_idx_i));
        check({"R10 portB ", tag_of(mode_i, rd_b_idx_i), extra}, rd_b_data_o, m_read(mode_i, rd_b_idx_i));
        check({bank_of(mode_i) == 0 ? "R8" : "R7", " psr", extra}, psr_rd_data_o, m_psr_read(mode_i));
        @(posedge clk);
        model_update();
        @(negedge clk);
        wr_en_i     = 1'b0;
        psr_wr_en_i = 1'b0;
    endtask

    task automatic do_write(logic [4:0] m, logic [3:0] idx, logic [31:0] d);
        mode_i = m; wr_en_i = 1'b1; wr_idx_i = idx; wr_data_i = d;
        rd_a_idx_i = idx; rd_b_idx_i = idx;     // R9: same-cycle read sees old value
        cycle(" R9");
    endtask

    task automatic sweep_reads(string extra);
        for (int mi = 0; mi < 8; mi++) begin
            for (int r = 0; r < 16; r++) begin
                mode_i = legal_modes[mi];
                rd_a_idx_i = 4'(r);
                rd_b_idx_i = 4'(15 - r);
                cycle(extra);
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            err_cnt++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
            $finish;
        end
    end

    initial begin
        model_clear();
        rst = 1'b1; mode_i = 5'b10000; rd_a_idx_i = '0; rd_b_idx_i = '0;
        wr_en_i = 1'b0; wr_idx_i = '0; wr_data_i = '0; pc_i = 32'hC0DE_0000;
        psr_wr_en_i = 1'b0; psr_wr_data_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_clear();
        rst = 1'b0;

        // R1: reset state seen in every mode
        sweep_reads(" R1");

        // R2/R5: user set, then banked copies for R3 and R4
        for (int r = 0; r < 15; r++) do_write(5'b10000, 4'(r), 32'h1000_0000 + r);
        for (int r = 8; r < 15; r++) do_write(5'b10001, 4'(r), 32'h2000_0000 + r);
        for (int mi = 2; mi < 6; mi++)
            for (int r = 13; r < 15; r++)
                do_write(legal_modes[mi], 4'(r), 32'h3000_0000 + (mi << 8) + r);
        do_write(5'b11111, 4'd3, 32'h5151_0003);      // system writes the shared set
        do_write(5'b01010, 4'd10, 32'h0BAD_000A);     // unlisted code reaches the user set
        do_write(5'b10001, 4'd2, 32'hF1F1_0002);      // R2: low register from fast mode
        pc_i = 32'hAAAA_5550;
        do_write(5'b10011, 4'd15, 32'hDEAD_BEEF);     // R6: discarded
        sweep_reads(" bank-sweep");

        // R7/R8: saved status words
        for (int mi = 0; mi < 8; mi++) begin
            mode_i = legal_modes[mi];
            psr_wr_en_i = 1'b1;
            psr_wr_data_i = 32'h6000_0000 + mi;
            cycle(" psr-write");
        end
        for (int mi = 0; mi < 8; mi++) begin
            mode_i = legal_modes[mi];
            cycle(" psr-read");
        end

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            mode_i        = legal_modes[$urandom_range(0, 7)];
            rd_a_idx_i    = 4'($urandom);
            rd_b_idx_i    = 4'($urandom);
            wr_en_i       = 1'($urandom);
            wr_idx_i      = ($urandom_range(0, 3) == 0) ? rd_a_idx_i : 4'($urandom);
            wr_data_i     = $urandom;
            psr_wr_en_i   = ($urandom_range(0, 3) == 0);
            psr_wr_data_i = $urandom;
            pc_i          = $urandom;
            cycle(" rand");
        end

        // R1: mid-run reset clears everything again
        rst = 1'b1;
        cycle(" R1");
        rst = 1'b0;
        sweep_reads(" R1 after");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

endmodule